// File: doc/BRIEF.md
# Hart Wait-for-Interrupt State Controller

This block runs the wait-for-interrupt phase of one hart. It is a two-state machine with the states ACTIVE and WAITING. The surrounding pipeline pulses `step_en` once per step. On that pulse the controller reads its inputs and the current state, and reports exactly one outcome for that step. The outcome is one of: retire normally, retire with an illegal-instruction fault, take an interrupt, go on to fetch, or keep waiting. A separate flag `oc_stepped` says whether an instruction retired in that step.

The transitions are:
- ENTER_WAIT (ACTIVE to WAITING): a wait instruction completes on a fetch step.
- WAKE (WAITING to ACTIVE): an interrupt that is enabled locally is pending.
- FORCED_EXIT (WAITING to ACTIVE): an external request ends the wait.
- HOLD_WAIT (WAITING to WAITING): nothing happens and the hart keeps waiting.
- DISPATCH (ACTIVE to ACTIVE): an interrupt is taken.
- RUN (ACTIVE to ACTIVE): the hart goes on to fetch.

The wake test looks only at the per-source enables. It ignores global enables and delegation. Interrupt arbitration, fetch and execution sit outside this block, which only receives their results.

Top module: `wfi_wait_ctrl`

## Requirements
- R1: After reset the controller is in ACTIVE (`is_waiting`=0) and all outcome outputs and `oc_stepped` are 0.
- R2: Each `step_en` pulse produces, on the following cycle only, exactly one asserted outcome among `oc_retire_ok`, `oc_retire_ill`, `oc_take_irq`, `oc_fetch` and `oc_waiting`. In a cycle without `step_en`, the next cycle shows no outcome and `is_waiting` is unchanged.
- R3: In ACTIVE with `irq_dispatch`=1, the outcome is take-interrupt with `oc_stepped`=0. `wait_insn` is ignored and the state stays ACTIVE.
- R4: In ACTIVE with `irq_dispatch`=0 and `wait_insn`=0, the outcome is fetch with `oc_stepped`=0, and the state stays ACTIVE.
- R5: In ACTIVE with `irq_dispatch`=0 and `wait_insn`=1, the outcome is fetch with `oc_stepped`=0, and the state becomes WAITING after that same clock edge.
- R6: In WAITING, if `irq_pend & irq_en` is nonzero, the outcome is retire-ok with `oc_stepped`=1 and the state becomes ACTIVE. `irq_dispatch` has no influence in WAITING.
- R7: In WAITING, an interrupt wake takes precedence over a simultaneous `force_exit`. The outcome is retire-ok regardless of privilege and `wait_trap_en`.
- R8: In WAITING with no enabled interrupt pending and `force_exit`=1, the state becomes ACTIVE with `oc_stepped`=1. The outcome is retire-ok when `cur_priv`=2'b11 (machine) or `wait_trap_en`=0. Otherwise it is retire-illegal. Privilege codes are 2'b00 user, 2'b01 supervisor and 2'b11 machine; the code 2'b10 counts as not machine.
- R9: In WAITING with no enabled interrupt pending and `force_exit`=0, the outcome is waiting with `oc_stepped`=0, and the state stays WAITING.
- R10: In WAITING, pending bits whose enable bit is 0 do not wake the hart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | One-cycle step pulse |
| wait_insn | input | 1 | The instruction of this fetch step was a wait instruction |
| irq_pend | input | IRQ_W | Pending interrupt bits |
| irq_en | input | IRQ_W | Per-source interrupt enable bits |
| irq_dispatch | input | 1 | Arbiter result: an interrupt is dispatchable now (used in ACTIVE) |
| cur_priv | input | 2 | Current privilege (00 U, 01 S, 11 M) |
| wait_trap_en | input | 1 | Forced exit from a lower privilege faults |
| force_exit | input | 1 | External request to leave WAITING |
| oc_retire_ok | output | 1 | Outcome: the instruction retired normally |
| oc_retire_ill | output | 1 | Outcome: the instruction retired with an illegal-instruction fault |
| oc_take_irq | output | 1 | Outcome: take the interrupt |
| oc_fetch | output | 1 | Outcome: go on to fetch |
| oc_waiting | output | 1 | Outcome: still waiting |
| oc_stepped | output | 1 | An instruction retired in this step |
| is_waiting | output | 1 | Current state is WAITING |

## Verification
On every cycle the assertions check four things:
- the outcome vector is one-hot and appears only after a step pulse;
- a wake always retires normally and returns the state to ACTIVE;
- an illegal retire only follows a forced exit from a lower privilege with trapping enabled;
- a dispatch step or a waiting step never reports a retirement.

Some behaviours only the bench's scenarios can show. One is wake taking precedence over a forced exit under each privilege. Another is that enabled-zero pending bits leave the hart waiting. The last is the full walk through every transition in sequence, run against an independent reference model over constrained random step streams.

// File: rtl/wfi_ctrl_pkg.sv
package wfi_ctrl_pkg;

    typedef enum logic {
        ST_ACTIVE  = 1'b0,
        ST_WAITING = 1'b1
    } hart_st_e;

    typedef enum logic [2:0] {
        OC_NONE     = 3'd0,
        OC_RET_OK   = 3'd1,
        OC_RET_ILL  = 3'd2,
        OC_TAKE_IRQ = 3'd3,
        OC_FETCH    = 3'd4,
        OC_WAIT     = 3'd5
    } outcome_e;

    typedef struct packed {
        logic ret_ok;
        logic ret_ill;
        logic take_irq;
        logic fetch;
        logic waiting;
    } outcome_vec_t;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

endpackage

// File: rtl/wfi_wake_detect.sv
module wfi_wake_detect #(
    parameter int IRQ_W = 32
) (
    input  logic [IRQ_W-1:0] pend,
    input  logic [IRQ_W-1:0] en,
    output logic             wake
);
    localparam int LAST = IRQ_W - 1;

    logic [IRQ_W-1:0] masked;
    logic [IRQ_W-1:0] chain;

    assign masked = pend & en;

    // running OR across the masked sources
    assign chain[0] = masked[0];
    generate
        for (genvar i = 1; i < IRQ_W; i++) begin : g_or
            assign chain[i] = chain[i-1] | masked[i];
        end
    endgenerate

    assign wake = chain[LAST];
endmodule

// File: rtl/wfi_exit_policy.sv
module wfi_exit_policy
    import wfi_ctrl_pkg::*;
(
    input  logic [1:0] cur_priv,
    input  logic       wait_trap_en,
    output logic       exit_legal
);
    always_comb begin
        exit_legal = (cur_priv == PRIV_M) || !wait_trap_en;
    end
endmodule

// File: rtl/wfi_outcome_reg.sv
module wfi_outcome_reg
    import wfi_ctrl_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  outcome_e     code,
    output outcome_vec_t vec_q,
    output logic         stepped_q
);
    outcome_vec_t vec_d;
    logic         stepped_d;

    always_comb begin
        vec_d     = '0;
        stepped_d = 1'b0;
        unique case (code)
            OC_RET_OK:   begin vec_d.ret_ok  = 1'b1; stepped_d = 1'b1; end
            OC_RET_ILL:  begin vec_d.ret_ill = 1'b1; stepped_d = 1'b1; end
            OC_TAKE_IRQ: vec_d.take_irq = 1'b1;
            OC_FETCH:    vec_d.fetch    = 1'b1;
            OC_WAIT:     vec_d.waiting  = 1'b1;
            default:     vec_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q     <= '0;
            stepped_q <= 1'b0;
        end else if (load) begin
            vec_q     <= vec_d;
            stepped_q <= stepped_d;
        end else begin
            vec_q     <= '0;
            stepped_q <= 1'b0;
        end
    end

    // R2
    onehot_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vec_q));

    // R2
    step_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ($countones(vec_q) == 1));
endmodule

// File: rtl/wfi_wait_ctrl.sv
module wfi_wait_ctrl
    import wfi_ctrl_pkg::*;
#(
    parameter int IRQ_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             wait_insn,
    input  logic [IRQ_W-1:0] irq_pend,
    input  logic [IRQ_W-1:0] irq_en,
    input  logic             irq_dispatch,
    input  logic [1:0]       cur_priv,
    input  logic             wait_trap_en,
    input  logic             force_exit,
    output logic             oc_retire_ok,
    output logic             oc_retire_ill,
    output logic             oc_take_irq,
    output logic             oc_fetch,
    output logic             oc_waiting,
    output logic             oc_stepped,
    output logic             is_waiting
);
    hart_st_e     state_q, state_d;
    outcome_e     code;
    outcome_vec_t vec;
    logic         wake;
    logic         exit_legal;

    wfi_wake_detect #(.IRQ_W(IRQ_W)) u_wake (
        .pend (irq_pend),
        .en   (irq_en),
        .wake (wake)
    );

    wfi_exit_policy u_policy (
        .cur_priv     (cur_priv),
        .wait_trap_en (wait_trap_en),
        .exit_legal   (exit_legal)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    // transition and outcome selection
    always_comb begin
        state_d = state_q;
        code    = OC_NONE;
        if (step_en) begin
            unique case (state_q)
                ST_ACTIVE: begin
                    if (irq_dispatch) begin
                        code = OC_TAKE_IRQ;            // DISPATCH
                    end else begin
                        code = OC_FETCH;               // RUN / ENTER_WAIT
                        if (wait_insn) state_d = ST_WAITING;
                    end
                end
                ST_WAITING: begin
                    if (wake) begin
                        code    = OC_RET_OK;           // WAKE
                        state_d = ST_ACTIVE;
                    end else if (force_exit) begin
                        code    = exit_legal ? OC_RET_OK : OC_RET_ILL;  // FORCED_EXIT
                        state_d = ST_ACTIVE;
                    end else begin
                        code = OC_WAIT;                // HOLD_WAIT
                    end
                end
                default: state_d = ST_ACTIVE;
            endcase
        end
    end

    // registered outcome stage
    wfi_outcome_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (step_en),
        .code      (code),
        .vec_q     (vec),
        .stepped_q (oc_stepped)
    );

    assign oc_retire_ok  = vec.ret_ok;
    assign oc_retire_ill = vec.ret_ill;
    assign oc_take_irq   = vec.take_irq;
    assign oc_fetch      = vec.fetch;
    assign oc_waiting    = vec.waiting;
    assign is_waiting    = (state_q == ST_WAITING);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> (!oc_retire_ok && !oc_retire_ill && !oc_take_irq &&
                      !oc_fetch && !oc_waiting && $stable(is_waiting)));

    // R3
    dispatch_no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_waiting && step_en && irq_dispatch) |=>
            (oc_take_irq && !oc_stepped && !is_waiting));

    // R6
    wake_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_waiting && step_en && wake) |=> (oc_retire_ok && oc_stepped && !is_waiting));

    // R8
    ill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_retire_ill |-> ($past(cur_priv) != PRIV_M && $past(wait_trap_en) &&
                           $past(force_exit) && !$past(wake)));

    // R9
    hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_waiting && step_en && !wake && !force_exit) |=>
            (oc_waiting && !oc_stepped && is_waiting));
endmodule

// File: tb/sim_wfi_wait_ctrl.sv
module sim_wfi_wait_ctrl;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step_en = 1'b0;
    logic         wait_insn = 1'b0;
    logic [W-1:0] irq_pend = '0;
    logic [W-1:0] irq_en = '0;
    logic         irq_dispatch = 1'b0;
    logic [1:0]   cur_priv = 2'b11;
    logic         wait_trap_en = 1'b0;
    logic         force_exit = 1'b0;
    logic oc_retire_ok, oc_retire_ill, oc_take_irq, oc_fetch, oc_waiting, oc_stepped, is_waiting;

    int total = 0;
    int bad = 0;
    logic m_wait = 1'b0;

    always #4 clk = ~clk;

    wfi_wait_ctrl #(.IRQ_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .wait_insn(wait_insn),
        .irq_pend(irq_pend), .irq_en(irq_en), .irq_dispatch(irq_dispatch),
        .cur_priv(cur_priv), .wait_trap_en(wait_trap_en), .force_exit(force_exit),
        .oc_retire_ok(oc_retire_ok), .oc_retire_ill(oc_retire_ill),
        .oc_take_irq(oc_take_irq), .oc_fetch(oc_fetch), .oc_waiting(oc_waiting),
        .oc_stepped(oc_stepped), .is_waiting(is_waiting)
    );

    // packed {state, ok, ill, irq, fetch, wait, stepped}
    function automatic logic [6:0] model(input logic w, input logic wi, input logic disp,
                                         input logic [W-1:0] p, input logic [W-1:0] e,
                                         input logic [1:0] pr, input logic tw, input logic fx);
        if (!w) begin
            if (disp)    return 7'b0_0010_00;
            else if (wi) return 7'b1_0001_00;
            else         return 7'b0_0001_00;
        end else begin
            if ((p & e) != '0)          return 7'b0_1000_01;
            else if (fx) begin
                if (pr == 2'b11 || !tw) return 7'b0_1000_01;
                else                    return 7'b0_0100_01;
            end else                    return 7'b1_0000_10;
        end
    endfunction

    function automatic logic [6:0] observed();
        return {is_waiting, oc_retire_ok, oc_retire_ill, oc_take_irq, oc_fetch, oc_waiting, oc_stepped};
    endfunction

    task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic do_step(input string tag, input logic wi, input logic disp,
                           input logic [W-1:0] p, input logic [W-1:0] e,
                           input logic [1:0] pr, input logic tw, input logic fx);
        logic [6:0] exp;
        exp = model(m_wait, wi, disp, p, e, pr, tw, fx);
        @(negedge clk);
        wait_insn = wi; irq_dispatch = disp; irq_pend = p; irq_en = e;
        cur_priv = pr; wait_trap_en = tw; force_exit = fx; step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        chk(tag, observed(), exp);
        m_wait = exp[6];
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        chk(tag, observed(), {m_wait, 6'b0});
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 reset", observed(), 7'b0);
        rst_n = 1'b1;
        idle("R1 after reset");
        idle("R2 idle active");

        do_step("R3 dispatch ignores wait insn", 1, 1, '0, '0, 2'b00, 1, 0);
        idle("R2 outcome lasts one cycle");
        do_step("R4 fetch", 0, 0, '0, '0, 2'b11, 0, 0);
        do_step("R5 enter wait", 1, 0, '0, '0, 2'b00, 1, 0);
        do_step("R9 R10 masked pending, dispatch ignored", 0, 1, 32'hFFFF_0000, 32'h0000_FFFF, 2'b00, 1, 0);
        idle("R2 idle keeps waiting");
        do_step("R6 wake", 0, 0, 32'h8000_0000, 32'h8000_0000, 2'b00, 1, 0);
        do_step("R5 enter wait", 1, 0, '0, '0, 2'b00, 1, 0);
        do_step("R7 wake beats forced exit", 0, 0, 32'h1, 32'h1, 2'b00, 1, 1);
        do_step("R5 enter wait", 1, 0, '0, '0, 2'b01, 1, 0);
        do_step("R8 forced exit S tw1 ill", 0, 0, 32'h1, 32'h0, 2'b01, 1, 1);
        do_step("R5 enter wait", 1, 0, '0, '0, 2'b11, 1, 0);
        do_step("R8 forced exit M tw1 ok", 0, 0, '0, '0, 2'b11, 1, 1);
        do_step("R5 enter wait", 1, 0, '0, '0, 2'b00, 0, 0);
        do_step("R8 forced exit U tw0 ok", 0, 0, '0, '0, 2'b00, 0, 1);
        do_step("R5 enter wait", 1, 0, '0, '0, 2'b10, 1, 0);
        do_step("R8 forced exit priv10 tw1 ill", 0, 0, '0, '0, 2'b10, 1, 1);

        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] p, e;
            p = $urandom();
            e = ($urandom_range(0, 2) == 0) ? $urandom() : '0;
            if ($urandom_range(0, 1) == 1) e = e & ~p;
            do_step("R2-R10 random", $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, p, e,
                    2'($urandom_range(0, 3)), $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0);
            if ($urandom_range(0, 3) == 0) idle("R2 random idle");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule